// File: doc/BRIEF.md
# ARINC 429 Oversampling Line Receiver

This block recovers 32-bit words from one ARINC 429 line, given as two digital levels: one for the positive leg and one for the negative leg. A divided sample tick samples the line at ten times the data rate. Each sample is sorted into one of four kinds: a one, a zero, a null, or an illegal state in which both legs are high. A bit is taken from a run of matching active samples that ends in a null.

After 32 bits the block builds the word. Bit position 31 carries the parity-check result in place of the raw bit. The word is copied into a holding register, and an active-low ready flag falls. A host reads the word as two 16-bit halves through a read strobe and a half-select input. Reading the upper half releases the flag.

Two instances make a dual receiver. Each instance has its own ready flag and its own read strobe.

Top module: `a429_rx_lane`

## Requirements
- R1: After reset the ready flag `rdy_n` is 1, and the holding register is 0. A read of either half returns 0.
- R2: A bit is accepted when at least 3 consecutive samples show the same active state and a null sample follows. `line_hi`=1 with `line_lo`=0 is a one, and the reverse is a zero. The first bit received lands in bit position 0 of the word, and the 32nd lands in position 31.
- R3: `rdy_n` goes to 0 one clock after the sample tick that takes the first null sample following the 32nd bit.
- R4: While `rd_n`=0, `data_out` shows word bits 15..0 when `half_sel`=0 and word bits 31..16 when `half_sel`=1. While `rd_n`=1, `data_out` is 0.
- R5: Bit position 31 of the word read out is 1 when the 32 received bits hold an odd number of ones, and 0 otherwise. Bit positions 30..0 are the received bits.
- R6: `rdy_n` returns to 1 one clock after a cycle with `rd_n`=0 and `half_sel`=1. A read of the lower half alone leaves it at 0.
- R7: A sample with both legs high aborts the word in progress. Bits that follow it are ignored until the next word boundary, so that word never sets `rdy_n`.
- R8: 31 consecutive null samples (more than 3 bit times) form a word boundary. A word with fewer than 32 bits is discarded without any effect on `rdy_n`. The next complete word is received normally.
- R9: A run of only 1 or 2 active samples followed by a null is ignored and adds no bit.
- R10: A new complete word that arrives before the previous one has been read replaces the held word.
- R11: With `rate_slow`=0 a sample is taken every `FAST_DIV` clocks. With `rate_slow`=1 a sample is taken every `SLOW_DIV` clocks, and a word sent at that slower pace is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low master reset |
| rate_slow | input | 1 | Selects the slow sample tick (1) or the fast sample tick (0) |
| line_hi | input | 1 | Digitized level of the positive line leg |
| line_lo | input | 1 | Digitized level of the negative line leg |
| rd_n | input | 1 | Active-low read strobe |
| half_sel | input | 1 | Selects the lower half (0) or the upper half (1) |
| rdy_n | output | 1 | Active-low word-available flag |
| data_out | output | 16 | Selected half of the held word, 0 when no read is active |

## Verification
A line sample counts only at a tick. `rdy_n` falls on the clock after the tick that takes the first null following bit 32. The bench therefore holds the last bit's active half, confirms that the flag is still high, applies one null sample, and checks for the low flag at the next falling edge.

`data_out` follows `rd_n` and `half_sel` in the same cycle, so it is checked 1 ns after the bench drives them. The flag's release is checked at the falling edge after the clock that saw the upper-half read. In slow mode every line state is held for `SLOW_DIV` clocks, so each state falls on exactly one tick whatever the divider phase.

// File: rtl/a429_rx_lane.sv
module a429_rx_lane #(
  parameter int FAST_DIV = 1,
  parameter int SLOW_DIV = 8,
  parameter int SPB      = 10,
  parameter int MINRUN   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rate_slow,
  input  logic        line_hi,
  input  logic        line_lo,
  input  logic        rd_n,
  input  logic        half_sel,
  output logic        rdy_n,
  output logic [15:0] data_out
);
  localparam int GAP = 3 * SPB + 1;
  localparam int NW  = $clog2(GAP + 1);
  localparam int DW  = $clog2(SLOW_DIV + 1);
  localparam int RW  = $clog2(MINRUN + 1);

  logic [DW-1:0] div_cnt;
  logic [DW-1:0] div_lim;
  logic          tick;

  assign div_lim = rate_slow ? DW'(SLOW_DIV - 1) : DW'(FAST_DIV - 1);
  assign tick    = (div_cnt >= div_lim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? '0 : div_cnt + 1'b1;

  logic s_one, s_nul, s_err;
  assign s_one = line_hi & ~line_lo;
  assign s_nul = ~line_hi & ~line_lo;
  assign s_err = line_hi & line_lo;

  logic [RW-1:0] run;
  logic          lvl;
  logic [5:0]    bit_cnt;
  logic          skip;
  logic [NW-1:0] null_cnt;
  logic [31:0]   shreg;
  logic [31:0]   hold;
  logic [31:0]   nxt;
  logic          accept, word_done, boundary;

  assign nxt       = {lvl, shreg[31:1]};
  assign accept    = tick && s_nul && (run == RW'(MINRUN)) && !skip && (bit_cnt < 6'd32);
  assign word_done = accept && (bit_cnt == 6'd31);
  assign boundary  = tick && s_nul && (null_cnt == NW'(GAP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= '0;
      lvl      <= 1'b0;
      bit_cnt  <= '0;
      skip     <= 1'b0;
      null_cnt <= '0;
      shreg    <= '0;
    end else if (tick) begin
      if (s_err) begin
        run      <= '0;
        skip     <= 1'b1;
        bit_cnt  <= '0;
        null_cnt <= '0;
      end else if (s_nul) begin
        run <= '0;
        if (null_cnt != NW'(GAP)) null_cnt <= null_cnt + 1'b1;
        if (boundary) begin
          bit_cnt <= '0;
          skip    <= 1'b0;
        end else if (accept) begin
          shreg   <= nxt;
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else begin
        null_cnt <= '0;
        if (run != '0 && lvl == s_one) begin
          if (run != RW'(MINRUN)) run <= run + 1'b1;
        end else begin
          run <= RW'(1);
          lvl <= s_one;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= '0;
      rdy_n <= 1'b1;
    end else if (word_done) begin
      hold  <= {^nxt, nxt[30:0]};
      rdy_n <= 1'b0;
    end else if (!rd_n && half_sel) begin
      rdy_n <= 1'b1;
    end
  end

  assign data_out = rd_n ? 16'h0000 : (half_sel ? hold[31:16] : hold[15:0]);

  AST_RDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !rdy_n); // R3
  AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && half_sel && !word_done) |=> rdy_n); // R6
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && s_err) |=> (bit_cnt == 6'd0 && skip)); // R7
  AST_GAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (bit_cnt == 6'd0 && !skip)); // R8
  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 6'd32); // R2
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> $stable(hold)); // R10
endmodule

// File: tb/sim_a429_rx_lane.sv
`timescale 1ns/1ps
module sim_a429_rx_lane;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_slow = 1'b0;
  logic line_hi = 1'b0, line_lo = 1'b0;
  logic rd_n = 1'b1, half_sel = 1'b0;
  logic rdy_n;
  logic [15:0] data_out;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  a429_rx_lane #(.FAST_DIV(1), .SLOW_DIV(8), .SPB(10), .MINRUN(3)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_slow(rate_slow), .line_hi(line_hi),
    .line_lo(line_lo), .rd_n(rd_n), .half_sel(half_sel), .rdy_n(rdy_n),
    .data_out(data_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] w);
    return {^w, w[30:0]};
  endfunction

  task automatic samp(input logic a, input logic b, input int k);
    @(negedge clk);
    line_hi = a; line_lo = b;
    repeat (k - 1) @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input int k);
    for (int i = 0; i < 5; i++) samp(v, ~v, k);
    for (int i = 0; i < 5; i++) samp(1'b0, 1'b0, k);
  endtask

  task automatic send_gap(input int k);
    for (int i = 0; i < 40; i++) samp(1'b0, 1'b0, k);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n, input int k);
    for (int i = 0; i < n; i++) send_bit(w[i], k);
  endtask

  task automatic send_word(input logic [31:0] w, input int k);
    send_bits(w, 32, k);
    send_gap(k);
  endtask

  task automatic read_check(input logic [31:0] exp, input string req);
    @(negedge clk); rd_n = 1'b0; half_sel = 1'b0;
    #1 chk({req, " lower half"}, 32'(data_out), 32'(exp[15:0]));
    @(negedge clk);
    chk("R6 lower-half read keeps ready low", 32'(rdy_n), 32'd0);
    half_sel = 1'b1;
    #1 chk({req, " upper half"}, 32'(data_out), 32'(exp[31:16]));
    @(negedge clk);
    chk("R6 ready released after upper half", 32'(rdy_n), 32'd1);
    rd_n = 1'b1; half_sel = 1'b0;
    #1 chk("R4 idle bus is zero", 32'(data_out), 32'd0);
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R1 ready high after reset", 32'(rdy_n), 32'd1);
    chk("R1 idle bus zero", 32'(data_out), 32'd0);
    rd_n = 1'b0; half_sel = 1'b0;
    #1 chk("R1 held lower half zero", 32'(data_out), 32'd0);
    half_sel = 1'b1;
    #1 chk("R1 held upper half zero", 32'(data_out), 32'd0);
    @(negedge clk); rd_n = 1'b1; half_sel = 1'b0;
  endtask

  task automatic test_ready_timing;
    logic [31:0] w = 32'h1234_5678;
    send_bits(w, 31, 1);
    for (int i = 0; i < 5; i++) samp(w[31], ~w[31], 1);
    chk("R3 ready still high before closing null", 32'(rdy_n), 32'd1);
    samp(1'b0, 1'b0, 1);
    @(negedge clk);
    chk("R3 ready low one clock after closing null", 32'(rdy_n), 32'd0);
    send_gap(1);
    read_check(model(w), "R2 R4 bit order");
  endtask

  task automatic test_parity;
    logic [31:0] ws [4] = '{32'h0000_0001, 32'h0000_0003, 32'h8000_0000, 32'hFFFF_FFFF};
    for (int i = 0; i < 4; i++) begin
      send_word(ws[i], 1);
      chk("R5 word completes", 32'(rdy_n), 32'd0);
      read_check(model(ws[i]), "R5 parity");
    end
  endtask

  task automatic test_glitch;
    logic [31:0] w = 32'hA5C3_0F69;
    send_bits(w, 10, 1);
    samp(1'b1, 1'b0, 1); samp(1'b1, 1'b0, 1);
    for (int i = 0; i < 5; i++) samp(1'b0, 1'b0, 1);
    samp(1'b0, 1'b1, 1);
    for (int i = 0; i < 5; i++) samp(1'b0, 1'b0, 1);
    for (int i = 10; i < 32; i++) send_bit(w[i], 1);
    send_gap(1);
    read_check(model(w), "R9 short runs ignored");
  endtask

  task automatic test_short;
    logic [31:0] w = 32'h0F0F_1234;
    send_bits(32'hFFFF_FFFF, 20, 1);
    send_gap(1);
    chk("R8 short word discarded", 32'(rdy_n), 32'd1);
    send_word(w, 1);
    read_check(model(w), "R8 word after boundary");
  endtask

  task automatic test_error;
    logic [31:0] w = 32'h55AA_33CC;
    send_bits(32'h0000_FFFF, 15, 1);
    samp(1'b1, 1'b1, 1);
    for (int i = 0; i < 5; i++) samp(1'b0, 1'b0, 1);
    send_bits(32'hFFFF_FFFF, 17, 1);
    send_gap(1);
    chk("R7 aborted word not published", 32'(rdy_n), 32'd1);
    send_word(w, 1);
    read_check(model(w), "R7 recovery");
  endtask

  task automatic test_overwrite;
    send_word(32'h1111_1111, 1);
    send_word(32'h2468_ACE0, 1);
    read_check(model(32'h2468_ACE0), "R10 newer word replaces");
  endtask

  task automatic test_slow;
    logic [31:0] w = 32'hC0DE_4321;
    @(negedge clk); rate_slow = 1'b1;
    send_word(w, 8);
    chk("R11 slow word completes", 32'(rdy_n), 32'd0);
    read_check(model(w), "R11 slow rate");
    @(negedge clk); rate_slow = 1'b0;
  endtask

  initial begin
    #760000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    send_gap(1);
    test_ready_timing();
    test_parity();
    test_glitch();
    test_short();
    test_error();
    test_overwrite();
    test_slow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule